// File: doc/BRIEF.md
# Indexed Block-Access Configuration Target on I2C

This block is an I2C target that holds a small bank of 8-bit configuration registers. The system clock oversamples SCL and SDA and finds start, repeated-start and stop conditions. The target answers to one fixed address and pulls SDA low through an open-drain enable, both to acknowledge and to send read data. The register contents are driven out in parallel so that nearby logic can use them.

Every write carries a starting index and then an explicit byte count, followed by the data. A read sets the index in a write phase and then issues a repeated start with the read address. The target answers with a length byte taken from the count register, and after it sends that many data bytes. Some fields cannot be changed from the bus: a five-bit strap value latched after reset, a vendor nibble, and a device code.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges address byte D2h (write) and D3h (read). For any other address byte it acknowledges nothing and ignores the rest of the transfer until the next start.
- R2: A write runs as address, index N, count X, then data. Each byte is acknowledged, and data byte k (from 0) is stored in register N+k.
- R3: Data bytes after the first X of a write are acknowledged and discarded.
- R4: The index advances after every data byte until it reaches one past the last register and then stays there. Writes at that point are acknowledged and discarded, and reads there return 00h.
- R5: After D3h the target first sends the value of register 8, and then the data bytes from the current index. A host NACK ends the read, and SDA is released from then on.
- R6: Register 8 resets to 0Fh and can be written. It sets how many data bytes follow the length byte. Once they have been sent, SDA is released and the host reads FFh.
- R7: Register 6 reads 01h (revision nibble in bits [7:4] is 0 by default, vendor nibble in bits [3:0] is 1) and register 7 reads 22h. Bus writes to either have no effect.
- R8: Register 1 bits [4:0] hold strap_i as captured on the first clock after reset. Later changes of strap_i and bus writes do not alter them. Bits [7:5] of register 1 can be written.
- R9: A stop or a start at any point, even in the middle of a byte, ends the transfer in progress. Bytes written before it are kept, and a new transfer then works normally.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, the writable registers are 00h, register 8 is 0Fh, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 5 | Strap value captured once after reset |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Register contents; register i sits in bits [8i+7:8i] |

## Verification
The checks assume that every SCL high and low phase, and every SDA setup before an SCL edge, lasts well beyond the synchronizer delay of about three clocks. They also assume SDA moves while SCL is high only to form a start or a stop. Under these conditions the drive-change property and the stop-to-idle property hold. The bench meets them by building each bit from phases of ten system clocks. It changes SDA only a full phase after SCL has fallen, and it models the line as the wired-AND of host and target.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} xfer_state_e;
  typedef enum logic [1:0] {RL_ADDR, RL_IDX, RL_CNT, RL_DATA} rx_role_e;

  localparam logic [7:0] ADDR_WR     = 8'hD2;
  localparam logic [7:0] ADDR_RD     = 8'hD3;
  localparam int         STRAP_W     = 5;
  localparam int         IDX_STRAP   = 1;
  localparam int         IDX_VID     = 6;
  localparam int         IDX_DID     = 7;
  localparam int         IDX_CNT     = 8;
  localparam logic [3:0] VENDOR_CODE = 4'h1;
  localparam logic [7:0] DEVICE_CODE = 8'h22;
  localparam logic [7:0] CNT_DEFAULT = 8'h0F;
endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter logic [3:0] REV_ID   = 4'h0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  we_i,
  input  logic [7:0]            waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [STRAP_W-1:0] strap_q;
  logic               cap_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q    <= '0;
      cap_done_q <= 1'b0;
    end else if (!cap_done_q) begin
      strap_q    <= strap_i;
      cap_done_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == IDX_CNT) ? CNT_DEFAULT : 8'h00;
    logic hit;
    assign hit = we_i && (waddr_i == 8'(i));
    if (i == IDX_STRAP) begin : g_strap
      logic [7-STRAP_W:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  hi_q <= '0;
        else if (hit) hi_q <= wdata_i[7:STRAP_W];
      end
      assign regs_o[i*8 +: 8] = {hi_q, strap_q};
    end else if (i == IDX_VID) begin : g_vid
      assign regs_o[i*8 +: 8] = {REV_ID, VENDOR_CODE};
    end else if (i == IDX_DID) begin : g_did
      assign regs_o[i*8 +: 8] = DEVICE_CODE;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= RST_VAL;
        else if (hit) q <= wdata_i;
      end
      assign regs_o[i*8 +: 8] = q;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == 8'(i)) rdata_o = regs_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        sda_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [7:0]  rdata_i,
  input  logic [7:0]  cnt_i,
  output logic        sda_oe_o,
  output logic        we_o,
  output logic [7:0]  ptr_o,
  output logic [7:0]  wdata_o,
  output xfer_state_e state_o
);
  localparam logic [7:0] PTR_END = 8'(NUM_REGS);

  xfer_state_e state_q;
  rx_role_e    role_q;
  logic [3:0]  bit_q;
  logic [7:0]  sh_q, ptr_q, left_q;
  logic        rd_q, mack_q;
  logic        byte_in, in_range;

  assign byte_in  = (bit_q == 4'd8);
  assign in_range = (ptr_q < PTR_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      role_q  <= RL_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      left_q  <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_RX;
      role_q  <= RL_ADDR;
      bit_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            bit_q <= bit_q + 4'd1;
          end else if (scl_fall_i && byte_in) begin
            bit_q   <= '0;
            state_q <= ST_ACK;
            unique case (role_q)
              RL_ADDR: begin
                if (sh_q == ADDR_WR) begin
                  rd_q   <= 1'b0;
                  role_q <= RL_IDX;
                end else if (sh_q == ADDR_RD) begin
                  rd_q <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              RL_IDX: begin
                ptr_q  <= sh_q;
                role_q <= RL_CNT;
              end
              RL_CNT: begin
                left_q <= sh_q;
                role_q <= RL_DATA;
              end
              default: begin
                if (left_q != 8'd0) left_q <= left_q - 8'd1;
                if (in_range)       ptr_q  <= ptr_q + 8'd1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rd_q) begin
              // length byte leads every read
              state_q <= ST_TX;
              sh_q    <= cnt_i;
              left_q  <= cnt_i;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_q == 4'd7) begin
              state_q <= ST_MACK;
              bit_q   <= '0;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q && left_q != 8'd0) begin
              state_q <= ST_TX;
              sh_q    <= rdata_i;
              left_q  <= left_q - 8'd1;
              if (in_range) ptr_q <= ptr_q + 8'd1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state_q == ST_ACK) || (state_q == ST_TX && !sh_q[7]);
  assign we_o     = (state_q == ST_RX) && scl_fall_i && byte_in && (role_q == RL_DATA)
                    && (left_q != 8'd0) && in_range && !start_i && !stop_i;
  assign ptr_o    = ptr_q;
  assign wdata_o  = sh_q;
  assign state_o  = state_q;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [3:0] REV_ID      = 4'h0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [STRAP_W-1:0]       strap_i,
  output logic                     sda_oe_o,
  output logic [NUM_REGS*8-1:0]    regs_o
);
  logic        scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic        reg_we;
  logic [7:0]  reg_waddr, reg_wdata, rdata;
  xfer_state_e fsm_state;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  cfg_i2c_fsm #(.NUM_REGS(NUM_REGS)) i_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_evt), .stop_i(stop_evt),
    .rdata_i(rdata), .cnt_i(regs_o[IDX_CNT*8 +: 8]),
    .sda_oe_o, .we_o(reg_we), .ptr_o(reg_waddr), .wdata_o(reg_wdata),
    .state_o(fsm_state)
  );

  cfg_i2c_bank #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) i_bank (
    .clk_i, .rst_ni, .strap_i,
    .we_i(reg_we), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
    .raddr_i(reg_waddr), .rdata_o(rdata), .regs_o
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input xfer_state_e        fsm_state,
  input logic               stop_evt,
  input logic               reg_we,
  input logic [7:0]         reg_waddr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         cnt_q,
  input logic [STRAP_W-1:0] strap_q,
  input logic [7:0]         did_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> fsm_state == ST_IDLE);

  p_we_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> reg_waddr < 8'(NUM_REGS));

  p_cnt_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we && reg_waddr == 8'(IDX_CNT)) |=> cnt_q == $past(reg_wdata));

  p_strap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> $stable(strap_q));

  p_did_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we && reg_waddr == 8'(IDX_DID)) |=> $stable(did_q));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .fsm_state, .stop_evt,
  .reg_we, .reg_waddr, .reg_wdata,
  .cnt_q(regs_o[cfg_i2c_pkg::IDX_CNT*8 +: 8]),
  .strap_q(regs_o[cfg_i2c_pkg::IDX_STRAP*8 +: cfg_i2c_pkg::STRAP_W]),
  .did_q(regs_o[cfg_i2c_pkg::IDX_DID*8 +: 8])
);

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_h = 1'b1;
  logic          sda_h = 1'b1;
  logic [4:0]    strap = 5'b10110;
  logic          sda_oe;
  logic [NR*8-1:0] regs;
  logic          sda_line;
  int            n_cmp = 0;
  int            n_bad = 0;
  int            oe_viol = 0;
  logic          oe_prev = 1'b0;

  assign sda_line = sda_h & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_target #(.NUM_REGS(NR)) i_cfg_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // R10: SDA drive may only move while SCL is low
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_h) oe_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] reg_at(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; tick(Q);
    scl_h = 1'b1; tick(2*Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      recv_bit(b);
      v[k] = b;
    end
    send_bit(~host_ack);
  endtask

  task automatic wr_xfer(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3, input string tag);
    logic ak;
    logic [7:0] d [4];
    d = '{b0, b1, b2, b3};
    bus_start();
    send_byte(8'hD2, ak); chk({"R1 write addr ack ", tag}, {7'd0, ak}, 8'd1);
    send_byte(idx, ak);   chk({"R2 index ack ", tag}, {7'd0, ak}, 8'd1);
    send_byte(cnt, ak);   chk({"R2 count ack ", tag}, {7'd0, ak}, 8'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ak);
      chk({"data ack ", tag}, {7'd0, ak}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic rd_open(input logic [7:0] idx);
    logic ak;
    bus_start();
    send_byte(8'hD2, ak); chk("R1 write addr ack (read)", {7'd0, ak}, 8'd1);
    send_byte(idx, ak);   chk("R5 index ack (read)", {7'd0, ak}, 8'd1);
    bus_start();
    send_byte(8'hD3, ak); chk("R1 read addr ack", {7'd0, ak}, 8'd1);
  endtask

  task automatic t_reset();
    chk("R11 reg0 reset", reg_at(0), 8'h00);
    chk("R11 reg8 reset", reg_at(8), 8'h0F);
    chk("R11 sda released", {7'd0, sda_oe}, 8'd0);
    chk("R7 reg6 value", reg_at(6), 8'h01);
    chk("R7 reg7 value", reg_at(7), 8'h22);
    chk("R8 reg1 strap capture", reg_at(1), 8'h16);
  endtask

  task automatic t_write_basic();
    wr_xfer(8'd2, 8'd3, 3, 8'hA1, 8'hB2, 8'hC3, 8'h00, "R2 basic");
    chk("R2 reg2", reg_at(2), 8'hA1);
    chk("R2 reg3", reg_at(3), 8'hB2);
    chk("R2 reg4", reg_at(4), 8'hC3);
  endtask

  task automatic t_count_limit();
    wr_xfer(8'd9, 8'd1, 2, 8'h11, 8'h22, 8'h00, 8'h00, "R3 over count");
    chk("R3 reg9 written", reg_at(9), 8'h11);
    chk("R3 reg10 untouched", reg_at(10), 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr_xfer(8'd8, 8'd1, 1, 8'h03, 8'h00, 8'h00, 8'h00, "R6 set length");
    chk("R6 reg8 written", reg_at(8), 8'h03);
    rd_open(8'd2);
    recv_byte(1'b1, v); chk("R5 length byte first", v, 8'h03);
    recv_byte(1'b1, v); chk("R5 data 0", v, 8'hA1);
    recv_byte(1'b1, v); chk("R5 data 1", v, 8'hB2);
    recv_byte(1'b1, v); chk("R5 data 2", v, 8'hC3);
    recv_byte(1'b0, v); chk("R6 released after length", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_bank_end();
    logic [7:0] v;
    wr_xfer(8'd14, 8'd4, 4, 8'h5A, 8'h6B, 8'h7C, 8'h8D, "R4 end of bank");
    chk("R4 reg14", reg_at(14), 8'h5A);
    chk("R4 reg15", reg_at(15), 8'h6B);
    chk("R4 no wrap reg0", reg_at(0), 8'h00);
    wr_xfer(8'd8, 8'd1, 1, 8'h02, 8'h00, 8'h00, 8'h00, "R6 length 2");
    rd_open(8'd15);
    recv_byte(1'b1, v); chk("R6 length byte", v, 8'h02);
    recv_byte(1'b1, v); chk("R4 read reg15", v, 8'h6B);
    recv_byte(1'b0, v); chk("R4 read past end", v, 8'h00);
    bus_stop();
  endtask

  task automatic t_readonly();
    wr_xfer(8'd6, 8'd2, 2, 8'hFF, 8'hFF, 8'h00, 8'h00, "R7 id write");
    chk("R7 reg6 unchanged", reg_at(6), 8'h01);
    chk("R7 reg7 unchanged", reg_at(7), 8'h22);
    wr_xfer(8'd1, 8'd1, 1, 8'hFF, 8'h00, 8'h00, 8'h00, "R8 strap write");
    chk("R8 reg1 high bits only", reg_at(1), 8'hF6);
    strap = 5'b01001;
    tick(Q);
    chk("R8 strap held", reg_at(1), 8'hF6);
  endtask

  task automatic t_bad_addr();
    logic ak;
    bus_start();
    send_byte(8'hA0, ak); chk("R1 foreign addr nack", {7'd0, ak}, 8'd0);
    send_byte(8'h00, ak); chk("R1 ignored after foreign", {7'd0, ak}, 8'd0);
    send_byte(8'h55, ak); chk("R1 still ignored", {7'd0, ak}, 8'd0);
    bus_stop();
    chk("R1 reg0 untouched", reg_at(0), 8'h00);
  endtask

  task automatic t_abort();
    logic ak;
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h00, ak);
    send_byte(8'h02, ak);
    send_byte(8'h77, ak); chk("R9 first byte ack", {7'd0, ak}, 8'd1);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    bus_stop();
    chk("R9 kept before stop", reg_at(0), 8'h77);
    chk("R9 next reg untouched", reg_at(1), 8'hF6);
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h00, ak);
    send_byte(8'h01, ak);
    bus_start();
    send_byte(8'hD2, ak); chk("R9 restart addr ack", {7'd0, ak}, 8'd1);
    send_byte(8'h05, ak);
    send_byte(8'h01, ak);
    send_byte(8'h66, ak); chk("R9 restart data ack", {7'd0, ak}, 8'd1);
    bus_stop();
    chk("R9 reg5 after restart", reg_at(5), 8'h66);
    chk("R9 reg0 kept", reg_at(0), 8'h77);
  endtask

  task automatic t_nack_end();
    logic [7:0] v;
    rd_open(8'd2);
    recv_byte(1'b1, v); chk("R5 length byte", v, 8'h02);
    recv_byte(1'b0, v); chk("R5 data before nack", v, 8'hA1);
    recv_byte(1'b0, v); chk("R5 released after nack", v, 8'hFF);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_basic();
    t_count_limit();
    t_read();
    t_bank_end();
    t_readonly();
    t_bad_addr();
    t_abort();
    t_nack_end();
    chk("R10 drive moved only with SCL low", 8'(oe_viol), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule